// File: doc/BRIEF.md
# Binary-Tree Parallel-to-Serial Converter

This block turns a 16-bit parallel word into a serial stream of one bit per fast-clock cycle. It does not use a single shift register running at the bit rate. The word passes through four ranks of 2:1 selector cells, with 8, 4, 2 and 1 cells. Each rank toggles at twice the rate of the rank before it, so only the last cell works at the full bit rate. Each cell captures its two inputs together. It passes the first one on, keeps the second in a holding flop, and releases the held bit half a rank period later.

All ranks run on one fast clock. A free-running divider counter supplies the rank timing as per-rank load and swap enables, where real hardware would use divided clocks and their complements. The upstream side sees a valid/ready pair. `word_ready` is a one-cycle strobe, repeated every 16 cycles, and it cannot be held off. A word is taken only on a cycle where `word_ready` and `word_valid` are both high. If `word_valid` is low on a strobe cycle, the slot is filled with 16 zero bits. The serializer never stalls, so back-pressure flows only toward the source: a source with no data lets the slot go idle. The source must not expect `word_ready` to wait for it.

Top module: `tree_serializer`

## Requirements
- R1: `word_ready` is high for exactly one cycle in every 16. After reset is released, it first rises in the 16th cycle, counting the first cycle with reset low as cycle 1.
- R2: A word is captured only on a cycle where `word_ready` and `word_valid` are both high. The captured value is whatever `word_in` holds in that cycle.
- R3: If a word is captured in cycle L, its bit 0 is on `ser_out` in cycle L+5 (LEVELS+1 cycles later).
- R4: Bit k of the captured word is on `ser_out` in cycle L+5+k, for k from 0 to 15. Words follow one another with no gap and no repeated bit.
- R5: If `word_valid` is low on a `word_ready` cycle, `ser_out` is 0 for the 16 bit slots that belong to that strobe, whatever `word_in` holds.
- R6: Reset is synchronous and active high. After any clock edge with `rst` high, `ser_out` and `word_ready` are 0. After release, no bit from a word captured before the reset ever appears on `ser_out`.
- R7: Values on `word_in` and `word_valid` in cycles without `word_ready` have no effect on `ser_out`.
- R8: Within a rank, capture and swap never occur in the same cycle. A rank captures only when the rank feeding it will hold its outputs steady through the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 16 | Parallel word; bit 0 is sent first |
| word_valid | input | 1 | Source has a word on `word_in` |
| word_ready | output | 1 | One-cycle capture strobe, every 16 cycles |
| ser_out | output | 1 | Serial bit stream |

## Verification
Single-bit words at each end of the word (0x0001 and 0x8000) show whether the bit order is reversed or rotated, because a wrong rank pairing moves the lone one to a predictable wrong slot. All-ones and alternating words expose a stuck holding flop or swapped swap phases. A long PRBS-7 run places every neighbour combination into every cell pairing. Idle slots carrying a non-zero `word_in`, together with junk data held valid between strobes, separate a correct capture window from one that samples on the wrong cycle or ignores `word_valid`. A reset in the middle of the stream shows that the ranks are flushed.

// File: rtl/ser_tree_pkg.sv
`timescale 1ns/1ps
package ser_tree_pkg;

  // First bit of rank m's bus in a flat tree vector where rank m has 2**m streams.
  function automatic int unsigned stage_base(input int unsigned lvl);
    return (1 << lvl) - 1;
  endfunction

  // Cycle offset of rank m inside the word period: each rank trails the wider one by one cycle.
  function automatic int unsigned stage_offset(input int unsigned levels, input int unsigned lvl);
    return levels - 1 - lvl;
  endfunction

endpackage

// File: rtl/ser_phase_gen.sv
`timescale 1ns/1ps
module ser_phase_gen #(
  parameter int unsigned LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic              word_ready,
  output logic [LEVELS-1:0] load_en,
  output logic [LEVELS-1:0] swap_en
);
  localparam int unsigned CW    = LEVELS;
  localparam int unsigned WIDTH = 1 << LEVELS;
  localparam logic [CW-1:0] LAST = '1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign word_ready = (cnt == LAST);

  // Rank m toggles with period 2**m, shifted so it samples one cycle after its source changes.
  for (genvar m = 0; m < LEVELS; m++) begin : g_en
    localparam int unsigned SPAN = 2 << m;
    localparam logic [CW-1:0] OFF  = CW'(ser_tree_pkg::stage_offset(LEVELS, m));
    localparam logic [CW-1:0] HALF = CW'(1 << m);
    localparam logic [CW-1:0] MASK = CW'(SPAN - 1);
    logic [CW-1:0] rel;
    assign rel        = (cnt - OFF) & MASK;
    assign load_en[m] = (rel == '0);
    assign swap_en[m] = (rel == HALF);
  end

  // Independent spacing counter for the strobe.
  localparam logic [CW:0] GAP_W = (CW+1)'(WIDTH - 1);
  logic [CW:0] gap;
  always_ff @(posedge clk) begin
    if (rst)             gap <= '0;
    else if (word_ready) gap <= '0;
    else                 gap <= gap + 1'b1;
  end

  assert_ready_period_R1: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> (gap == GAP_W));

endmodule

// File: rtl/ser_mux_cell.sv
`timescale 1ns/1ps
module ser_mux_cell (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic swap_en,
  input  logic in_first,
  input  logic in_second,
  output logic q
);
  logic held;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= 1'b0;
      held <= 1'b0;
    end else if (load_en) begin
      q    <= in_first;
      held <= in_second;
    end else if (swap_en) begin
      q    <= held;
    end
  end

  // R8: the feeding rank must not move in the cycle after a capture.
  assert_input_settled_R8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> ($stable(in_first) && $stable(in_second)));

endmodule

// File: rtl/ser_rank.sv
`timescale 1ns/1ps
module ser_rank #(
  parameter int unsigned CELLS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               swap_en,
  input  logic [2*CELLS-1:0] src,
  output logic [CELLS-1:0]   dst
);
  // Stream j carries bit positions congruent to j modulo CELLS; it interleaves src j then src j+CELLS.
  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    ser_mux_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .load_en   (load_en),
      .swap_en   (swap_en),
      .in_first  (src[j]),
      .in_second (src[j+CELLS]),
      .q         (dst[j])
    );
  end

  assert_phase_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(load_en && swap_en));

endmodule

// File: rtl/tree_serializer.sv
`timescale 1ns/1ps
module tree_serializer #(
  parameter  int unsigned LEVELS = 4,
  localparam int unsigned WIDTH  = 1 << LEVELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] word_in,
  input  logic             word_valid,
  output logic             word_ready,
  output logic             ser_out
);
  localparam int unsigned TREE_BITS = 2*WIDTH - 1;
  localparam int unsigned LAT       = LEVELS + 1;

  logic [LEVELS-1:0]    load_en;
  logic [LEVELS-1:0]    swap_en;
  logic [WIDTH-1:0]     word_q;
  logic [TREE_BITS-1:0] tree;

  ser_phase_gen #(.LEVELS(LEVELS)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .word_ready (word_ready),
    .load_en    (load_en),
    .swap_en    (swap_en)
  );

  // Word capture: an idle strobe loads zeros.
  always_ff @(posedge clk) begin
    if (rst)             word_q <= '0;
    else if (word_ready) word_q <= word_valid ? word_in : '0;
  end

  assign tree[TREE_BITS-1 -: WIDTH] = word_q;

  for (genvar m = 0; m < LEVELS; m++) begin : g_rank
    localparam int unsigned N   = 1 << m;
    localparam int unsigned DST = ser_tree_pkg::stage_base(m);
    localparam int unsigned SRC = ser_tree_pkg::stage_base(m + 1);
    ser_rank #(.CELLS(N)) u_rank (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en[m]),
      .swap_en (swap_en[m]),
      .src     (tree[SRC +: 2*N]),
      .dst     (tree[DST +: N])
    );
  end

  assign ser_out = tree[0];

  // Checker state: cycles since reset, saturating at the latency.
  localparam int unsigned WW = $clog2(LAT + 1);
  localparam logic [WW-1:0] LAT_W = WW'(LAT);
  logic [WW-1:0] warm;
  logic          take;
  always_ff @(posedge clk) begin
    if (rst)                warm <= '0;
    else if (warm != LAT_W) warm <= warm + 1'b1;
  end
  assign take = word_ready && word_valid;

  assert_first_bit_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (warm == LAT_W && $past(take, LAT)) |-> (ser_out == $past(word_in[0], LAT)));

  assert_idle_slot_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (warm == LAT_W && $past(word_ready && !word_valid, LAT)) |-> !ser_out);

  assert_reset_clears_R6: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out && !word_ready));

endmodule

// File: tb/tree_serializer_tb.sv
`timescale 1ns/1ps
module tree_serializer_tb;
  localparam int unsigned LEVELS = 4;
  localparam int unsigned WIDTH  = 16;
  localparam int          LAT    = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] word_in = '0;
  logic             word_valid = 1'b0;
  logic             word_ready;
  logic             ser_out;

  tree_serializer #(.LEVELS(LEVELS)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .word_in    (word_in),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .ser_out    (ser_out)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run  = 0;
  int n_fail = 0;

  typedef struct packed {
    int         t;
    logic       v;
    logic [7:0] tag;
  } exp_s;
  exp_s sb[$];

  logic [6:0] lfsr = 7'h7F;

  function automatic string tag_name(input logic [7:0] c);
    case (c)
      8'd2:    return "R2";
      8'd3:    return "R3";
      8'd4:    return "R4";
      8'd5:    return "R5";
      8'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // PRBS-7, x^7 + x^6 + 1; the word's bit k is the k-th new bit.
  task automatic next_word(output logic [WIDTH-1:0] w);
    for (int k = 0; k < WIDTH; k++) begin
      logic nb;
      nb   = lfsr[6] ^ lfsr[5];
      lfsr = {lfsr[5:0], nb};
      w[k] = nb;
    end
  endtask

  // Driver: waits for the strobe, offers one slot, pushes expected bits.
  task automatic slot(input logic valid, input logic [WIDTH-1:0] w, input logic [7:0] tag, input bit junk);
    forever begin
      @(posedge clk); #1;
      if (word_ready) break;
      if (junk) begin
        word_in    = ~w ^ WIDTH'(cyc * 40503);
        word_valid = 1'b1;  // R7: valid without ready must be ignored
      end else begin
        word_in    = '0;
        word_valid = 1'b0;
      end
    end
    word_in    = w;
    word_valid = valid;
    for (int k = 0; k < WIDTH; k++) begin
      exp_s e;
      e.t   = cyc + LAT + k;
      e.v   = valid ? w[k] : 1'b0;
      e.tag = !valid ? 8'd5 : (k == 0 ? 8'd3 : tag);
      sb.push_back(e);
    end
  endtask

  // Monitor: scoreboard comparison away from the active edge.
  logic rst_prev = 1'b0;
  int   rel_cyc  = 0;
  int   last_rdy = -1;
  always @(negedge clk) begin
    if (rst) begin
      if (rst_prev) begin
        check_bit("R6", ser_out, 1'b0, "serial out during reset");
        check_bit("R6", word_ready, 1'b0, "strobe during reset");
      end
      last_rdy = -1;
    end else begin
      if (rst_prev) rel_cyc = cyc;
      if (word_ready) begin
        if (last_rdy < 0) check_int("R1", cyc - rel_cyc, WIDTH - 1, "first strobe offset");
        else              check_int("R1", cyc - last_rdy, WIDTH, "strobe spacing");
        last_rdy = cyc;
      end
      // Each bit also depends on correct rank capture timing (R8).
      if (sb.size() > 0 && sb[0].t == cyc) begin
        exp_s e;
        e = sb.pop_front();
        check_bit(tag_name(e.tag), ser_out, e.v, "serial bit");
      end else begin
        check_bit("R6", ser_out, 1'b0, "no word in flight");
      end
    end
    rst_prev = rst;
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    logic [WIDTH-1:0] w;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R4 corner words: ordering, stuck flops, phase swaps.
    slot(1'b1, 16'h0001, 8'd4, 1'b0);
    slot(1'b1, 16'h8000, 8'd4, 1'b0);
    slot(1'b1, 16'hFFFF, 8'd4, 1'b0);
    slot(1'b1, 16'hAAAA, 8'd4, 1'b0);
    slot(1'b1, 16'h1234, 8'd4, 1'b0);
    slot(1'b0, 16'hBEEF, 8'd5, 1'b0);  // R5: idle slot with data present

    for (int i = 0; i < 1100; i++) begin
      next_word(w);
      if (i % 37 == 36)    slot(1'b0, w, 8'd5, 1'b1);
      else if (i % 4 == 1) slot(1'b1, w, 8'd7, 1'b1);
      else                 slot(1'b1, w, 8'd2, 1'b0);
    end

    // R6: reset mid-stream, words in flight must vanish.
    @(posedge clk); #1;
    rst        = 1'b1;
    word_valid = 1'b0;
    sb.delete();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;

    slot(1'b1, 16'hC3A5, 8'd6, 1'b0);
    for (int i = 0; i < 8; i++) begin
      next_word(w);
      slot(1'b1, w, 8'd2, 1'b0);
    end
    @(posedge clk); #1;
    word_valid = 1'b0;
    repeat (LAT + 2*WIDTH) @(posedge clk);
    @(negedge clk);
    check_int("R4", sb.size(), 0, "scoreboard drained");
    finish_run();
  end

endmodule